// File: doc/BRIEF.md
# Half-Step Bouncing Sequence Counter

This block free-runs through a fixed 15-cycle pattern on a 3-bit output. The output climbs one per cycle from 0 to 7 and then falls back to 1. On the way down the value 4 stays for two cycles; on the way up it shows for one. After the final 1 the pattern starts again at 0 and repeats for as long as the clock runs.

The counter keeps a register one bit wider than the output, and the output is the upper bits of that register. The register normally moves by two per cycle, which steps the visible value by one. In a small window on the descent it moves by one, so the visible value holds for one extra cycle. No hold state is needed. A one-bit direction register decides whether the count rises or falls, and it also drives an output. The reset input is asynchronous and active low. Inside the block the release of reset is synchronised to the clock.

Top module: `halfstep_bounce_counter`

## Requirements
- R1: While reset is held low, and for the two clock edges after its release, `count_o` reads 0 and `descending_o` reads 0. Asserting reset clears both outputs at once, without waiting for a clock edge.
- R2: While `descending_o` is 0 and `count_o` is below 7, each clock edge raises `count_o` by exactly one, and `descending_o` stays 0.
- R3: When `count_o` is 7 with `descending_o` at 0, the next edge gives `count_o` = 6 and `descending_o` = 1.
- R4: While descending, `count_o` drops by one per edge, except for the single hold described in R5.
- R5: The value 4 appears on two consecutive cycles during the descent. During the ascent it appears on only one cycle. No other value is ever held.
- R6: When `count_o` is 1 with `descending_o` at 1, the next edge gives `count_o` = 0 and `descending_o` = 0. The full period is 15 cycles: 0,1,2,3,4,5,6,7,6,5,4,4,3,2,1.
- R7: `descending_o` is 1 exactly on the seven cycles that show 6,5,4,4,3,2,1 of the descent, and 0 on the eight cycles that show 0 through 7.
- R8: A reset applied in the middle of a period restarts the pattern from 0 on the ascent, whatever the phase at the time of the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| count_o | output | 3 | Visible sequence value (upper bits of the internal half-step register) |
| descending_o | output | 1 | 1 while the pattern is on its falling half |

## Verification
The bench lets the counter run for several unbroken periods and compares every cycle with the 15-entry pattern. This separates a correct turn at the peak and the floor from an early or late turn, and it catches a wrong period length. A separate scan counts how often 4 appears in each direction. This shows whether the hold sits on the descent only, or has drifted onto the ascent or onto a neighbouring value. Resets are applied at several phases, including the peak, the hold itself and the last descending value. These show that the restart does not depend on where the pattern was, and that the asynchronous clear acts before any clock edge.

// File: rtl/bounce_pkg.sv
package bounce_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

endpackage

// File: rtl/bounce_rst_sync.sv
// Asserts reset immediately and releases it only after STAGES clock edges.
module bounce_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bounce_next.sv
// Next-state logic for the half-step register.
// The register moves by two per cycle, and by one inside the dwell window on the descent.
module bounce_next
  import bounce_pkg::*;
#(
  parameter int ACC_W = 4
) (
  input  logic [ACC_W-1:0] acc_q,
  input  dir_e             dir_q,
  output logic [ACC_W-1:0] acc_nxt,
  output dir_e             dir_nxt
);

  // Peak is the largest even code; the floor is the code that shows 1.
  localparam logic [ACC_W-1:0] PEAK      = ACC_W'((1 << ACC_W) - 2);
  localparam logic [ACC_W-1:0] FLOOR     = ACC_W'(2);
  localparam int               DWELL_OUT = 1 << (ACC_W - 2);
  // Codes from which a single-unit step is taken: just above the dwell value, and its odd half.
  localparam logic [ACC_W-1:0] WIN_HI    = ACC_W'(2 * DWELL_OUT + 2);
  localparam logic [ACC_W-1:0] WIN_LO    = ACC_W'(2 * DWELL_OUT + 1);
  localparam logic [ACC_W-1:0] STEP_ONE  = ACC_W'(1);
  localparam logic [ACC_W-1:0] STEP_TWO  = ACC_W'(2);

  logic in_window;

  always_comb begin
    in_window = (acc_q == WIN_HI) || (acc_q == WIN_LO);
    acc_nxt   = acc_q;
    dir_nxt   = dir_q;
    unique case (dir_q)
      DIR_UP: begin
        acc_nxt = acc_q + STEP_TWO;
        if (acc_q == PEAK) begin
          acc_nxt = acc_q - STEP_TWO;
          dir_nxt = DIR_DOWN;
        end
      end
      DIR_DOWN: begin
        if (acc_q == FLOOR) begin
          acc_nxt = '0;
          dir_nxt = DIR_UP;
        end else if (in_window) begin
          acc_nxt = acc_q - STEP_ONE;
        end else begin
          acc_nxt = acc_q - STEP_TWO;
        end
      end
      default: begin
        acc_nxt = '0;
        dir_nxt = DIR_UP;
      end
    endcase
  end

endmodule

// File: rtl/halfstep_bounce_counter.sv
module halfstep_bounce_counter
  import bounce_pkg::*;
#(
  parameter int OUT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] count_o,
  output logic             descending_o
);

  localparam int               ACC_W   = OUT_W + 1;
  localparam logic [OUT_W-1:0] TOP_VAL = '1;
  localparam logic [OUT_W-1:0] ONE_VAL = OUT_W'(1);

  logic             rst_sync_n;
  logic [ACC_W-1:0] acc_q, acc_nxt;
  dir_e             dir_q, dir_nxt;

  bounce_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bounce_next #(.ACC_W(ACC_W)) u_next (
    .acc_q   (acc_q),
    .dir_q   (dir_q),
    .acc_nxt (acc_nxt),
    .dir_nxt (dir_nxt)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      acc_q <= acc_nxt;
      dir_q <= dir_nxt;
    end
  end

  assign count_o      = acc_q[ACC_W-1:1];
  assign descending_o = (dir_q == DIR_DOWN);

  // Assertions
  p_ascent_step_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!descending_o && count_o != TOP_VAL) |=> (!descending_o && count_o == $past(count_o) + ONE_VAL));

  p_peak_turn_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!descending_o && count_o == TOP_VAL) |=> (descending_o && count_o == TOP_VAL - ONE_VAL));

  // An even register code on the descent (other than the floor) is always followed by a visible decrement.
  p_descent_step_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (descending_o && !acc_q[0] && count_o != ONE_VAL) |=> (descending_o && count_o == $past(count_o) - ONE_VAL));

  // The odd half-step code is the only hold, and it appears only on the descent.
  p_hold_only_down_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_q[0] |-> descending_o);

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (descending_o && acc_q[0]) |=> (descending_o && $stable(count_o)));

  p_floor_wrap_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (descending_o && count_o == ONE_VAL) |=> (!descending_o && count_o == '0));

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (count_o == '0 && !descending_o));

endmodule

// File: tb/halfstep_bounce_counter_tb_top.sv
`timescale 1ns/1ps
module halfstep_bounce_counter_tb_top;

  logic       clk;
  logic       rst_n;
  logic [2:0] count_o;
  logic       descending_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  halfstep_bounce_counter dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .count_o      (count_o),
    .descending_o (descending_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_count(input int idx);
    if (idx < 8)        return idx;
    else if (idx <= 10) return 14 - idx;
    else                return 15 - idx;
  endfunction

  function automatic bit exp_desc(input int idx);
    return (idx >= 8);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Release reset at a falling edge, then wait for the two synchroniser edges.
  // The sample after that corresponds to pattern index 0.
  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  // Advance one clock and sample at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", count_o, 0);
    check("R1 descending in reset", descending_o, 0);
    release_reset();
    check("R1 count after release", count_o, 0);
    check("R1 descending after release", descending_o, 0);
  endtask

  // Starting at index 0, compare several full periods.
  task automatic t_periods(input int periods);
    for (int k = 1; k <= periods * 15; k++) begin
      step();
      check($sformatf("R2/R3/R4/R6 count idx %0d", k % 15), count_o, exp_count(k % 15));
      check($sformatf("R7 descending idx %0d", k % 15), descending_o, exp_desc(k % 15));
    end
  endtask

  // Count how often 4 is seen in each direction over one period (starts at index 0).
  task automatic t_dwell_direction();
    int fours_up = 0;
    int fours_dn = 0;
    int holds    = 0;
    int prev     = count_o;
    for (int k = 1; k <= 15; k++) begin
      step();
      if (count_o == 4 && !descending_o) fours_up++;
      if (count_o == 4 &&  descending_o) fours_dn++;
      if (count_o == prev) holds++;
      prev = count_o;
    end
    check("R5 fours on ascent", fours_up, 1);
    check("R5 fours on descent", fours_dn, 2);
    check("R5 total holds per period", holds, 1);
  endtask

  // Run to pattern index 'phase', assert reset there, and check the restart.
  task automatic t_mid_reset(input int phase);
    for (int k = 1; k <= phase; k++) step();
    check($sformatf("R8 pre-reset phase %0d", phase), count_o, exp_count(phase));
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear count", count_o, 0);
    check("R1 async clear descending", descending_o, 0);
    @(negedge clk);
    release_reset();
    check("R8 restart count", count_o, 0);
    for (int k = 1; k <= 15; k++) begin
      step();
      check($sformatf("R8 after reset idx %0d", k % 15), count_o, exp_count(k % 15));
      check($sformatf("R8 descending idx %0d", k % 15), descending_o, exp_desc(k % 15));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset_state();
    t_periods(4);
    t_dwell_direction();
    t_mid_reset(7);
    t_mid_reset(11);
    t_mid_reset(14);
    t_mid_reset(3);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule